// File: doc/BRIEF.md
# Extended State Save Sequencer

This block turns one save request into an ordered stream of memory write beats that dump the x87 floating-point state and the vector (XMM) register file into a save area. A one-cycle `start` pulse carries a base address, a 64-bit requested-component mask and the enabled-component register. The block first checks the request for faults. If it finds none, it walks the enabled and requested components and drives one write beat at a time on a valid/ready interface. It reads the register files through index ports as it goes.

Each beat carries an exact byte address, a 128-bit data line and 16 byte enables. A 16-byte beat has an address aligned to 16 bytes, with all enables set. A 4-byte beat places its dword in lane `addr[3:2]` of the data line. Only that lane's four enables are set, and the other bits of the line are zero. When the last beat has been accepted, a single `done` pulse follows. A faulting request produces a one-cycle fault report in place of any beats.

Top module: `xstate_save_seq`

## Requirements
- R1: When `osEnable` is 0 at `start`, `faultValid` is high in the cycle after `start` with `faultCode` = 1. No beat is issued and no `done` is raised. This check takes priority over the R2 and R3 checks.
- R2: When `osEnable` is 1 and `taskSwitched` is 1 at `start`, the fault code is 2. It appears with the same timing as R1, and no beat is issued.
- R3: When the first two checks pass and `baseAddr[5:0]` is not 0, the fault code is 3. It appears with the same timing as R1, and no write beat is issued.
- R4: The x87 component is written only when bit 0 is set in both `enMask` and `reqMask`. The SSE component is written only when bit 1 is set in both. All other mask bits have no effect.
- R5: The x87 header beat goes to offset 0 as a 16-byte beat. Its 16-bit lanes 0 to 3 hold, in order, the control word, the status word, the compressed tag byte (zero-extended) and the opcode. The upper 64 bits hold the instruction pointer field.
- R6: Bit i of the compressed tag byte is 1 exactly when bits [2i+1:2i] of `fpuTag` are not 2'b11.
- R7: The upper 64 bits of the header beat depend on `opSize64`. When it is 1, they hold `fpuIp[63:0]`, the dword at offset 16 is `fpuDp[31:0]` and the dword at offset 20 is `fpuDp[63:32]`. When it is 0, they hold {16'h0, `fpuCs`, `fpuIp[31:0]`}, and the dword at offset 20 is {16'h0, `fpuDs`}. Dword beats use byte enables 16'hF << (4·addr[3:2]).
- R8: x87 register i (0 to 7) is written as a 16-byte beat at offset 32+16·i. The beat holds the 64-bit fraction in bits [63:0] and the 16-bit exponent in bits [79:64], with zeros above.
- R9: For SSE, `mxcsr` is a dword at offset 24 and `mxcsrMask` a dword at offset 28. XMM register i is a 16-byte beat at offset 160+16·i.
- R10: XMM registers 8 to 15 are written only when `longMode` is 1 at `start`. Otherwise registers 0 to 7 are written.
- R11: Beats are issued in this order: header, data-pointer dwords (16 then 20), x87 registers 0 upward, the SSE control dwords (24 then 28), then XMM registers upward. While `wrReady` is low, the pending beat's address, data and enables stay unchanged.
- R12: `done` is a one-cycle pulse in the cycle after the last accepted beat. It comes in the cycle after `start` when no component is selected, and it is never raised for a faulting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle save request, taken while the block is idle |
| baseAddr | input | ADDR_W | Linear base address of the save area |
| reqMask | input | 64 | Requested-component mask |
| enMask | input | 64 | Enabled-component register |
| osEnable | input | 1 | OS support enable for extended save |
| taskSwitched | input | 1 | Task-switched flag |
| longMode | input | 1 | 64-bit mode flag |
| opSize64 | input | 1 | 64-bit operand size flag |
| fpuCtrl | input | 16 | x87 control word |
| fpuStat | input | 16 | x87 status word |
| fpuTag | input | 16 | Full x87 tag word |
| fpuOpc | input | 16 | Last x87 opcode |
| fpuIp | input | 64 | x87 instruction pointer |
| fpuCs | input | 16 | x87 code selector |
| fpuDp | input | 64 | x87 data pointer |
| fpuDs | input | 16 | x87 data selector |
| mxcsr | input | 32 | SSE control/status |
| mxcsrMask | input | 32 | SSE control/status mask |
| x87Idx | output | 3 | x87 register read index |
| x87Frac | input | 64 | Fraction of the indexed x87 register |
| x87Exp | input | 16 | Sign/exponent of the indexed x87 register |
| xmmIdx | output | $clog2(NUM_XMM) | XMM register read index |
| xmmData | input | 128 | Indexed XMM register |
| wrValid | output | 1 | Write beat valid |
| wrReady | input | 1 | Write beat accepted when high with `wrValid` |
| wrAddr | output | ADDR_W | Byte address of the beat |
| wrData | output | 128 | Lane-positioned beat data |
| wrBe | output | 16 | Byte enables within the 16-byte line |
| done | output | 1 | Request complete pulse |
| faultValid | output | 1 | Fault report pulse |
| faultCode | output | 2 | 0 none, 1 invalid opcode, 2 device not available, 3 general protection |

## Verification
The assertions assume that `start` arrives only while the block is idle. They also assume that the architectural inputs (FPU fields, control dwords and both register files) hold steady from `start` until `done` or the fault report, because the stall-stability property covers only address and enables. The stimulus keeps to this. It sets every state input at a falling edge before the start pulse and leaves it unchanged until the request completes. It changes `wrReady` only at falling edges, following a fixed per-vector pattern, so that stalls land on header, pointer, register and control beats alike.

// File: rtl/xsave_pkg.sv
package xsave_pkg;

  localparam int IDX_W     = 4;
  localparam int FPR_COUNT = 8;

  localparam logic [11:0] OFF_DPLO = 12'd16;
  localparam logic [11:0] OFF_DPHI = 12'd20;
  localparam logic [11:0] OFF_MXC  = 12'd24;
  localparam logic [11:0] OFF_MXM  = 12'd28;
  localparam logic [11:0] OFF_FPR  = 12'd32;
  localparam logic [11:0] OFF_XMM  = OFF_FPR + 12'(16 * FPR_COUNT);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FAULT, ST_HDR, ST_DPLO, ST_DPHI,
    ST_FPR, ST_MXC, ST_MXM, ST_XMM, ST_DONE
  } seqState_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_UD = 2'd1, FLT_NM = 2'd2, FLT_GP = 2'd3
  } faultCode_e;

  typedef struct packed {
    logic             capture;
    seqState_e        kind;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;

endpackage

// File: rtl/xsave_ctrl.sv
module xsave_ctrl
  import xsave_pkg::*;
#(
  parameter int NUM_XMM        = 16,
  parameter int NUM_XMM_LEGACY = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       osEnable,
  input  logic       taskSwitched,
  input  logic [5:0] baseLow,
  input  logic [1:0] enBits,
  input  logic [1:0] reqBits,
  input  logic       longMode,
  input  logic       wrReady,
  output logic       wrValid,
  output logic       done,
  output logic       faultValid,
  output logic [1:0] faultCode,
  output dpStrobe_t  strobe
);

  localparam logic [IDX_W-1:0] FPR_LAST = IDX_W'(FPR_COUNT - 1);
  localparam logic [IDX_W-1:0] XMM_ALL  = IDX_W'(NUM_XMM - 1);
  localparam logic [IDX_W-1:0] XMM_LEG  = IDX_W'(NUM_XMM_LEGACY - 1);

  seqState_e        state, nxtState;
  logic [IDX_W-1:0] idx, nxtIdx, lastXmm;
  logic             doSse;
  faultCode_e       faultReg, faultNext;
  logic             x87Go, sseGo, fire;

  assign x87Go = enBits[0] & reqBits[0];
  assign sseGo = enBits[1] & reqBits[1];
  assign fire  = wrValid & wrReady;

  always_comb begin
    if (!osEnable)         faultNext = FLT_UD;
    else if (taskSwitched) faultNext = FLT_NM;
    else if (|baseLow)     faultNext = FLT_GP;
    else                   faultNext = FLT_NONE;
  end

  always_comb begin
    nxtState = state;
    nxtIdx   = idx;
    unique case (state)
      ST_IDLE: if (start) begin
        nxtIdx = '0;
        if (faultNext != FLT_NONE) nxtState = ST_FAULT;
        else if (x87Go)            nxtState = ST_HDR;
        else if (sseGo)            nxtState = ST_MXC;
        else                       nxtState = ST_DONE;
      end
      ST_FAULT: nxtState = ST_IDLE;
      ST_DONE:  nxtState = ST_IDLE;
      ST_HDR:   if (fire) nxtState = ST_DPLO;
      ST_DPLO:  if (fire) nxtState = ST_DPHI;
      ST_DPHI:  if (fire) nxtState = ST_FPR;
      ST_FPR: if (fire) begin
        if (idx == FPR_LAST) begin
          nxtIdx   = '0;
          nxtState = doSse ? ST_MXC : ST_DONE;
        end else nxtIdx = idx + 1'b1;
      end
      ST_MXC:   if (fire) nxtState = ST_MXM;
      ST_MXM:   if (fire) nxtState = ST_XMM;
      ST_XMM: if (fire) begin
        if (idx == lastXmm) nxtState = ST_DONE;
        else                nxtIdx = idx + 1'b1;
      end
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idx      <= '0;
      doSse    <= 1'b0;
      lastXmm  <= XMM_LEG;
      faultReg <= FLT_NONE;
    end else begin
      state <= nxtState;
      idx   <= nxtIdx;
      if (state == ST_IDLE && start) begin
        doSse    <= sseGo;
        lastXmm  <= longMode ? XMM_ALL : XMM_LEG;
        faultReg <= faultNext;
      end
    end
  end

  assign wrValid    = state inside {ST_HDR, ST_DPLO, ST_DPHI, ST_FPR, ST_MXC, ST_MXM, ST_XMM};
  assign done       = (state == ST_DONE);
  assign faultValid = (state == ST_FAULT);
  assign faultCode  = faultValid ? faultReg : FLT_NONE;

  assign strobe.capture = (state == ST_IDLE) && start;
  assign strobe.kind    = state;
  assign strobe.idx     = idx;

  // R1
  fault_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(start));

  // R12
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(fire) || $past(start)));

endmodule

// File: rtl/xsave_dpath.sv
module xsave_dpath
  import xsave_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_XMM = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  logic                       opSize64,
  input  logic [15:0]                fpuCtrl,
  input  logic [15:0]                fpuStat,
  input  logic [15:0]                fpuTag,
  input  logic [15:0]                fpuOpc,
  input  logic [63:0]                fpuIp,
  input  logic [15:0]                fpuCs,
  input  logic [63:0]                fpuDp,
  input  logic [15:0]                fpuDs,
  input  logic [31:0]                mxcsr,
  input  logic [31:0]                mxcsrMask,
  input  logic [63:0]                x87Frac,
  input  logic [15:0]                x87Exp,
  input  logic [127:0]               xmmData,
  output logic [2:0]                 x87Idx,
  output logic [$clog2(NUM_XMM)-1:0] xmmIdx,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [127:0]               wrData,
  output logic [15:0]                wrBe
);

  localparam int XIDX_W = $clog2(NUM_XMM);

  logic [ADDR_W-1:0]    baseQ;
  logic                 op64Q;
  logic [FPR_COUNT-1:0] tagByte;
  logic [63:0]          hiPtr;
  logic [11:0]          off;
  logic [31:0]          dword;
  logic                 isDword;
  logic [127:0]         line;
  logic [1:0]           laneSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      op64Q <= 1'b0;
    end else if (strobe.capture) begin
      baseQ <= baseAddr;
      op64Q <= opSize64;
    end
  end

  for (genvar g = 0; g < FPR_COUNT; g++) begin : g_tag
    assign tagByte[g] = (fpuTag[2*g +: 2] != 2'b11);
  end

  assign hiPtr = op64Q ? fpuIp : {16'h0, fpuCs, fpuIp[31:0]};

  always_comb begin
    off     = '0;
    dword   = '0;
    isDword = 1'b0;
    line    = '0;
    case (strobe.kind)
      ST_HDR:  line = {hiPtr, fpuOpc, 8'h00, tagByte, fpuStat, fpuCtrl};
      ST_DPLO: begin off = OFF_DPLO; isDword = 1'b1; dword = fpuDp[31:0]; end
      ST_DPHI: begin
        off = OFF_DPHI; isDword = 1'b1;
        dword = op64Q ? fpuDp[63:32] : {16'h0, fpuDs};
      end
      ST_FPR: begin
        off  = OFF_FPR + {4'b0, strobe.idx, 4'b0};
        line = {48'h0, x87Exp, x87Frac};
      end
      ST_MXC:  begin off = OFF_MXC; isDword = 1'b1; dword = mxcsr; end
      ST_MXM:  begin off = OFF_MXM; isDword = 1'b1; dword = mxcsrMask; end
      ST_XMM: begin
        off  = OFF_XMM + {4'b0, strobe.idx, 4'b0};
        line = xmmData;
      end
      default: ;
    endcase
  end

  assign laneSel = off[3:2];
  assign wrData  = isDword ? (128'(dword) << {laneSel, 5'b0}) : line;
  assign wrBe    = isDword ? (16'hF << {laneSel, 2'b0}) : 16'hFFFF;
  assign wrAddr  = baseQ + {{(ADDR_W-12){1'b0}}, off};
  assign x87Idx  = strobe.idx[2:0];
  assign xmmIdx  = strobe.idx[XIDX_W-1:0];

endmodule

// File: rtl/xstate_save_seq.sv
module xstate_save_seq
  import xsave_pkg::*;
#(
  parameter int ADDR_W         = 48,
  parameter int NUM_XMM        = 16,
  parameter int NUM_XMM_LEGACY = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  logic [63:0]                reqMask,
  input  logic [63:0]                enMask,
  input  logic                       osEnable,
  input  logic                       taskSwitched,
  input  logic                       longMode,
  input  logic                       opSize64,
  input  logic [15:0]                fpuCtrl,
  input  logic [15:0]                fpuStat,
  input  logic [15:0]                fpuTag,
  input  logic [15:0]                fpuOpc,
  input  logic [63:0]                fpuIp,
  input  logic [15:0]                fpuCs,
  input  logic [63:0]                fpuDp,
  input  logic [15:0]                fpuDs,
  input  logic [31:0]                mxcsr,
  input  logic [31:0]                mxcsrMask,
  output logic [2:0]                 x87Idx,
  input  logic [63:0]                x87Frac,
  input  logic [15:0]                x87Exp,
  output logic [$clog2(NUM_XMM)-1:0] xmmIdx,
  input  logic [127:0]               xmmData,
  output logic                       wrValid,
  input  logic                       wrReady,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [127:0]               wrData,
  output logic [15:0]                wrBe,
  output logic                       done,
  output logic                       faultValid,
  output logic [1:0]                 faultCode
);

  dpStrobe_t strobe;
  logic      unusedMaskBits;

  assign unusedMaskBits = ^{reqMask[63:2], enMask[63:2]};

  xsave_ctrl #(.NUM_XMM(NUM_XMM), .NUM_XMM_LEGACY(NUM_XMM_LEGACY)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .osEnable(osEnable),
    .taskSwitched(taskSwitched), .baseLow(baseAddr[5:0]),
    .enBits(enMask[1:0]), .reqBits(reqMask[1:0]), .longMode(longMode),
    .wrReady(wrReady), .wrValid(wrValid), .done(done),
    .faultValid(faultValid), .faultCode(faultCode), .strobe(strobe)
  );

  xsave_dpath #(.ADDR_W(ADDR_W), .NUM_XMM(NUM_XMM)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .opSize64(opSize64), .fpuCtrl(fpuCtrl), .fpuStat(fpuStat),
    .fpuTag(fpuTag), .fpuOpc(fpuOpc), .fpuIp(fpuIp), .fpuCs(fpuCs),
    .fpuDp(fpuDp), .fpuDs(fpuDs), .mxcsr(mxcsr), .mxcsrMask(mxcsrMask),
    .x87Frac(x87Frac), .x87Exp(x87Exp), .xmmData(xmmData),
    .x87Idx(x87Idx), .xmmIdx(xmmIdx), .wrAddr(wrAddr),
    .wrData(wrData), .wrBe(wrBe)
  );

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrBe)));

  // R3
  gp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode == 2'd3) |-> ($past(baseAddr[5:0]) != 6'd0));

  // R1
  ud_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode == 2'd1) |-> !$past(osEnable));

  // R8
  line_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrBe == 16'hFFFF) |-> (wrAddr[3:0] == 4'd0));

  // R7
  dword_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrBe != 16'hFFFF) |->
      ($countones(wrBe) == 4 && (wrBe >> {wrAddr[3:2], 2'b00}) == 16'h000F));

endmodule

// File: tb/sim_xstate_save_seq.sv
`timescale 1ns/1ps
module sim_xstate_save_seq;

  typedef struct packed {
    logic [1:0]  en;
    logic [1:0]  req;
    logic        lm;
    logic        op64;
    logic [47:0] base;
    logic [15:0] tag;
    logic [3:0]  rdy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 2'b11, 1'b1, 1'b1, 48'h0000_0000_1000, 16'h0000, 4'hF},
    '{2'b11, 2'b11, 1'b0, 1'b0, 48'h0000_0000_2040, 16'hFFFF, 4'h5},
    '{2'b01, 2'b11, 1'b1, 1'b0, 48'h0000_0000_3000, 16'h3C1B, 4'hE},
    '{2'b11, 2'b10, 1'b1, 1'b1, 48'h0000_0000_40C0, 16'hAAAA, 4'h9},
    '{2'b10, 2'b01, 1'b1, 1'b1, 48'h0000_0000_5000, 16'h0000, 4'hF},
    '{2'b11, 2'b11, 1'b1, 1'b0, 48'h0000_0001_6100, 16'hF00F, 4'h7}
  };

  logic         clk = 0, rstN = 0, start = 0;
  logic [47:0]  baseAddr = '0;
  logic [63:0]  reqMask = '0, enMask = '0;
  logic         osEnable = 1, taskSwitched = 0, longMode = 0, opSize64 = 0;
  logic [15:0]  fpuCtrl = 16'h037F, fpuStat = 16'h3800, fpuTag = 16'h0, fpuOpc = 16'h07AB;
  logic [63:0]  fpuIp = 64'h0000_1234_5678_9ABC, fpuDp = 64'h0000_7654_3210_FEDC;
  logic [15:0]  fpuCs = 16'h0023, fpuDs = 16'h002B;
  logic [31:0]  mxcsr = 32'h0000_1F80, mxcsrMask = 32'h0000_FFFF;
  logic [2:0]   x87Idx;
  logic [3:0]   xmmIdx;
  logic [63:0]  x87Frac;
  logic [15:0]  x87Exp;
  logic [127:0] xmmData;
  logic         wrValid, wrReady = 0, done, faultValid;
  logic [47:0]  wrAddr;
  logic [127:0] wrData;
  logic [15:0]  wrBe;
  logic [1:0]   faultCode;

  int nChecks = 0, nFail = 0;

  function automatic logic [63:0] fracOf(input int i);
    return 64'h8000_0000_0000_005A | (64'(i) << 8);
  endfunction
  function automatic logic [15:0] expOf(input int i);
    return 16'h3FF0 + 16'(i);
  endfunction
  function automatic logic [127:0] xmmOf(input int i);
    return {32'hC0DE_0000 + 32'(i), 32'h1111_0000 + 32'(i),
            32'h2222_0000 + 32'(i), 32'h3333_0000 + 32'(i)};
  endfunction

  assign x87Frac = fracOf(int'(x87Idx));
  assign x87Exp  = expOf(int'(x87Idx));
  assign xmmData = xmmOf(int'(xmmIdx));

  always #5 clk = ~clk;

  xstate_save_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .reqMask(reqMask), .enMask(enMask), .osEnable(osEnable),
    .taskSwitched(taskSwitched), .longMode(longMode), .opSize64(opSize64),
    .fpuCtrl(fpuCtrl), .fpuStat(fpuStat), .fpuTag(fpuTag), .fpuOpc(fpuOpc),
    .fpuIp(fpuIp), .fpuCs(fpuCs), .fpuDp(fpuDp), .fpuDs(fpuDs),
    .mxcsr(mxcsr), .mxcsrMask(mxcsrMask), .x87Idx(x87Idx),
    .x87Frac(x87Frac), .x87Exp(x87Exp), .xmmIdx(xmmIdx), .xmmData(xmmData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .done(done), .faultValid(faultValid), .faultCode(faultCode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected beats
  logic [47:0]  eAddr [64];
  logic [127:0] eData [64];
  logic [15:0]  eBe   [64];
  string        eReq  [64];
  int           eN;
  // observed beats
  logic [47:0]  gAddr [64];
  logic [127:0] gData [64];
  logic [15:0]  gBe   [64];
  int gN, lastAcc, doneCyc, faultCyc;
  logic [1:0] gCode;
  bit stallBad;

  task automatic addExp(input logic [47:0] a, input logic [127:0] d,
                        input logic [15:0] be, input string r);
    eAddr[eN] = a; eData[eN] = d; eBe[eN] = be; eReq[eN] = r; eN++;
  endtask

  task automatic buildExp(input vec_t v);
    logic [7:0]  tb;
    logic [63:0] hi;
    eN = 0;
    for (int i = 0; i < 8; i++) tb[i] = (v.tag[2*i +: 2] != 2'b11);
    hi = v.op64 ? fpuIp : {16'h0, fpuCs, fpuIp[31:0]};
    if (v.en[0] && v.req[0]) begin
      addExp(v.base, {hi, fpuOpc, 8'h00, tb, fpuStat, fpuCtrl}, 16'hFFFF, "R5/R6");
      addExp(v.base + 48'd16, {96'h0, fpuDp[31:0]}, 16'h000F, "R7");
      addExp(v.base + 48'd20,
             {64'h0, (v.op64 ? fpuDp[63:32] : {16'h0, fpuDs}), 32'h0}, 16'h00F0, "R7");
      for (int i = 0; i < 8; i++)
        addExp(v.base + 48'(32 + 16*i), {48'h0, expOf(i), fracOf(i)}, 16'hFFFF, "R8");
    end
    if (v.en[1] && v.req[1]) begin
      addExp(v.base + 48'd24, {32'h0, mxcsr, 64'h0}, 16'h0F00, "R9");
      addExp(v.base + 48'd28, {mxcsrMask, 96'h0}, 16'hF000, "R9");
      for (int i = 0; i < (v.lm ? 16 : 8); i++)
        addExp(v.base + 48'(160 + 16*i), xmmOf(i), 16'hFFFF, (i >= 8) ? "R10" : "R9");
    end
  endtask

  // issue one request and watch the write interface
  task automatic runReq(input vec_t v, input logic osEn, input logic ts);
    logic [47:0]  pA;
    logic [127:0] pD;
    logic [15:0]  pB;
    bit pend;
    @(negedge clk);
    baseAddr = v.base; longMode = v.lm; opSize64 = v.op64; fpuTag = v.tag;
    enMask  = {{31{2'b10}}, v.en};
    reqMask = {{31{2'b01}}, v.req};
    osEnable = osEn; taskSwitched = ts;
    start = 1;
    @(negedge clk);
    start = 0;
    gN = 0; lastAcc = -1; doneCyc = -1; faultCyc = -1; gCode = 2'd0;
    stallBad = 0; pend = 0; pA = '0; pD = '0; pB = '0;
    for (int c = 0; c < 120; c++) begin
      wrReady = v.rdy[c % 4];
      #1;
      if (faultValid && faultCyc < 0) begin faultCyc = c; gCode = faultCode; end
      if (done) begin doneCyc = c; break; end
      if (wrValid) begin
        if (pend && (wrAddr != pA || wrData != pD || wrBe != pB)) stallBad = 1;
        if (wrReady) begin
          gAddr[gN] = wrAddr; gData[gN] = wrData; gBe[gN] = wrBe;
          gN++; lastAcc = c; pend = 0;
        end else begin
          pend = 1; pA = wrAddr; pD = wrData; pB = wrBe;
        end
      end
      if (faultCyc >= 0 && c >= faultCyc + 4) break;
      @(negedge clk);
    end
    wrReady = 0;
  endtask

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R11 R12 R1: idle after reset
    chk(!wrValid, "R11", "reset wrValid", 128'(wrValid), 128'h0);
    chk(!done, "R12", "reset done", 128'(done), 128'h0);
    chk(!faultValid, "R1", "reset faultValid", 128'(faultValid), 128'h0);

    for (int k = 0; k < NV; k++) begin
      buildExp(VECS[k]);
      runReq(VECS[k], 1'b1, 1'b0);
      chk(faultCyc < 0, "R1", $sformatf("vec%0d no fault", k), 128'(faultCyc), 128'hFFFFFFFF);
      chk(gN == eN, "R4/R10", $sformatf("vec%0d beat count", k), 128'(gN), 128'(eN));
      for (int b = 0; b < eN && b < gN; b++) begin
        chk(gAddr[b] == eAddr[b], eReq[b], $sformatf("vec%0d beat%0d addr R11", k, b),
            128'(gAddr[b]), 128'(eAddr[b]));
        chk(gData[b] == eData[b], eReq[b], $sformatf("vec%0d beat%0d data", k, b),
            gData[b], eData[b]);
        chk(gBe[b] == eBe[b], eReq[b], $sformatf("vec%0d beat%0d be", k, b),
            128'(gBe[b]), 128'(eBe[b]));
      end
      chk(!stallBad, "R11", $sformatf("vec%0d stall hold", k), 128'(stallBad), 128'h0);
      chk(doneCyc == ((eN == 0) ? 0 : lastAcc + 1), "R12",
          $sformatf("vec%0d done cycle", k), 128'(doneCyc), 128'((eN == 0) ? 0 : lastAcc + 1));
    end

    // R1: OS enable clear wins over misalignment
    runReq('{2'b11, 2'b11, 1'b1, 1'b1, 48'h1008, 16'h0, 4'hF}, 1'b0, 1'b1);
    chk(faultCyc == 0 && gCode == 2'd1, "R1", "UD code/timing", 128'({faultCyc[7:0], 6'h0, gCode}), 128'h1);
    chk(gN == 0 && doneCyc < 0, "R1", "UD no beats/done", 128'(gN), 128'h0);

    // R2: task switched
    runReq('{2'b11, 2'b11, 1'b1, 1'b1, 48'h1008, 16'h0, 4'hF}, 1'b1, 1'b1);
    chk(faultCyc == 0 && gCode == 2'd2, "R2", "NM code/timing", 128'({faultCyc[7:0], 6'h0, gCode}), 128'h2);
    chk(gN == 0 && doneCyc < 0, "R2", "NM no beats/done", 128'(gN), 128'h0);

    // R3: misaligned base
    runReq('{2'b11, 2'b11, 1'b1, 1'b1, 48'h1020, 16'h0, 4'hF}, 1'b1, 1'b0);
    chk(faultCyc == 0 && gCode == 2'd3, "R3", "GP code/timing", 128'({faultCyc[7:0], 6'h0, gCode}), 128'h3);
    chk(gN == 0 && doneCyc < 0, "R3", "GP no beats/done", 128'(gN), 128'h0);

    // R4: a request after a fault still runs normally
    buildExp(VECS[2]);
    runReq(VECS[2], 1'b1, 1'b0);
    chk(gN == eN && faultCyc < 0, "R4", "post-fault x87 only", 128'(gN), 128'(eN));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule